// File: doc/BRIEF.md
# Four-Step Vector Word Dot-Product Accumulator

This execution unit updates a 512-bit accumulator made of sixteen signed 32-bit lanes. One operation takes four steps. Each step reads one source vector from a register-file read port. The four source vectors are consecutive registers, and the first of them sits on a boundary of four. In every step each lane takes two adjacent signed 16-bit words from the current source vector. It multiplies them by the two signed words of one 32-bit element of a 128-bit operand that is shared by all lanes, and adds both products to its running sum. The element used advances by one in each step.

When the operation finishes, a per-lane mask decides what each lane of the result holds. The lane can take the new sum, or it can be cleared or keep its old value, depending on the mode. A separate combinational flag tells the load path whether the 128-bit operand has to be fetched at all. Control uses a start pulse, a busy level and a single-cycle done pulse. The result is held at the output until the next operation starts.

Top module: `quad_step_dotacc`

## Requirements
- R1: After reset, busyOut and doneOut are both low.
- R2: When a start is accepted at a clock edge, busyOut is high for the next 4 cycles and doneOut is high for exactly one cycle after that. resultOut is valid while doneOut is high.
- R3: In the k-th busy cycle (k = 0 to 3), rfIdxOut equals the captured source index with its two low bits cleared, plus k. rfDataIn is consumed in that same cycle.
- R4: In step k, lane i multiplies source bits [32i+15:32i] by operand bits [32k+15:32k], and source bits [32i+31:32i+16] by operand bits [32k+31:32k+16]. All four values are signed 16-bit two's complement, and both products are added into the lane.
- R5: Lane arithmetic wraps modulo 2^32, with no saturation.
- R6: A lane whose mask bit is 1, or any lane when maskEnIn is 0, outputs its original value plus all eight products.
- R7: A lane whose mask bit is 0, with maskEnIn = 1 and zeroModeIn = 1, outputs zero.
- R8: A lane whose mask bit is 0, with maskEnIn = 1 and zeroModeIn = 0, outputs its accumulator value as captured at start.
- R9: fetchNeededOut is 1 when maskEnIn is 0 or when any bit of maskIn is 1. Otherwise it is 0.
- R10: startIn is ignored while busyOut is high. The mask, the mode bits, mulOpIn, accInVec and srcIdxIn are captured when a start is accepted, and later changes to them do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Starts an operation when the unit is idle |
| srcIdxIn | input | 5 | Index of a register in the source block |
| mulOpIn | input | 128 | Shared operand, four 32-bit elements each holding two signed words |
| accInVec | input | 512 | Accumulator value before the operation |
| maskIn | input | 16 | Per-lane write mask |
| maskEnIn | input | 1 | 1 = apply the mask, 0 = every lane is written |
| zeroModeIn | input | 1 | 1 = masked lanes are cleared, 0 = masked lanes keep their old value |
| rfIdxOut | output | 5 | Register-file read index |
| rfDataIn | input | 512 | Register-file read data, valid in the same cycle as the index |
| fetchNeededOut | output | 1 | The 128-bit operand must be loaded |
| busyOut | output | 1 | Operation in progress |
| doneOut | output | 1 | One-cycle pulse, result valid |
| resultOut | output | 512 | Final 16-lane vector |

## Verification
Random source vectors and operands use the full signed range, so a wrong word pairing, a wrong step-to-element mapping or lost sign extension gives a different sum. Directed cases push extreme values: the most negative word squared in every product, and large positive products added to a lane already near its maximum. These show whether the lanes wrap and keep the sign correctly. Mixed masks are run in both zeroing and merge mode, and with masking turned off, so that the three lane outcomes can be told apart in one vector. In some runs the inputs are changed and start is held high while the unit is busy, to show that everything was captured at start.

// File: rtl/qdot_pkg.sv
package qdot_pkg;
  localparam int LANES  = 16;
  localparam int WORD   = 16;
  localparam int DWORD  = 2 * WORD;
  localparam int STEPS  = 4;
  localparam int VEC    = LANES * DWORD;
  localparam int OPW    = STEPS * DWORD;
  localparam int IDXW   = 5;
  localparam int STEPW  = $clog2(STEPS);

  typedef struct packed {
    logic             load;
    logic             stepEn;
    logic [STEPW-1:0] stepIdx;
  } ctrl_t;
endpackage

// File: rtl/qdot_ctrl.sv
module qdot_ctrl
  import qdot_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            startIn,
  input  logic [IDXW-1:0] srcIdxIn,
  output logic            busyOut,
  output logic            doneOut,
  output logic [IDXW-1:0] rfIdxOut,
  output ctrl_t           ctrlOut
);
  localparam logic [STEPW-1:0] LAST_STEP = STEPW'(STEPS - 1);
  localparam logic [IDXW-1:0]  BASE_MASK = ~IDXW'(STEPS - 1);

  logic             busyQ, doneQ;
  logic [STEPW-1:0] stepQ;
  logic [IDXW-1:0]  baseQ;
  logic             accept;

  assign accept = startIn && !busyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      stepQ <= '0;
      baseQ <= '0;
    end else begin
      doneQ <= 1'b0;
      if (accept) begin
        busyQ <= 1'b1;
        stepQ <= '0;
        baseQ <= srcIdxIn & BASE_MASK;
      end else if (busyQ) begin
        stepQ <= stepQ + 1'b1;
        if (stepQ == LAST_STEP) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end
      end
    end
  end

  assign rfIdxOut        = baseQ | IDXW'(stepQ);
  assign busyOut         = busyQ;
  assign doneOut         = doneQ;
  assign ctrlOut.load    = accept;
  assign ctrlOut.stepEn  = busyQ;
  assign ctrlOut.stepIdx = stepQ;

  // R2: done only ever follows a busy cycle
  a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> $past(busyQ));
  // R2: done is a single-cycle pulse
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);
  // R3: read index walks up by one inside an operation
  a_r3_index_walk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && $past(busyQ) && !$past(accept)) |-> rfIdxOut == $past(rfIdxOut) + 1'b1);
  // R10: a start while busy does not restart the step count
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && startIn && stepQ != LAST_STEP) |=> (busyQ && stepQ != '0));
endmodule

// File: rtl/qdot_lanes.sv
module qdot_lanes
  import qdot_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctrlIn,
  input  logic [OPW-1:0]   mulOpIn,
  input  logic [VEC-1:0]   accInVec,
  input  logic [LANES-1:0] maskIn,
  input  logic             maskEnIn,
  input  logic             zeroModeIn,
  input  logic [VEC-1:0]   rfDataIn,
  output logic [VEC-1:0]   resultOut
);
  logic [VEC-1:0]   accQ, origQ, accNext;
  logic [OPW-1:0]   opQ;
  logic [LANES-1:0] maskQ;
  logic             maskEnQ, zeroQ;
  logic [DWORD-1:0] opElem;
  logic [DWORD-1:0] opLoX, opHiX;

  assign opElem = opQ[ctrlIn.stepIdx*DWORD +: DWORD];
  assign opLoX  = {{(DWORD-WORD){opElem[WORD-1]}},  opElem[WORD-1:0]};
  assign opHiX  = {{(DWORD-WORD){opElem[DWORD-1]}}, opElem[DWORD-1:WORD]};

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [DWORD-1:0] srcLoX, srcHiX, prodLo, prodHi, laneAcc;
    logic             takeNew;
    assign srcLoX  = {{(DWORD-WORD){rfDataIn[g*DWORD+WORD-1]}},  rfDataIn[g*DWORD +: WORD]};
    assign srcHiX  = {{(DWORD-WORD){rfDataIn[g*DWORD+DWORD-1]}}, rfDataIn[g*DWORD+WORD +: WORD]};
    assign prodLo  = srcLoX * opLoX;
    assign prodHi  = srcHiX * opHiX;
    assign laneAcc = accQ[g*DWORD +: DWORD];
    assign accNext[g*DWORD +: DWORD] = laneAcc + prodLo + prodHi;
    assign takeNew = !maskEnQ || maskQ[g];
    assign resultOut[g*DWORD +: DWORD] = takeNew ? laneAcc :
                                         (zeroQ ? '0 : origQ[g*DWORD +: DWORD]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ    <= '0;
      origQ   <= '0;
      opQ     <= '0;
      maskQ   <= '0;
      maskEnQ <= 1'b0;
      zeroQ   <= 1'b0;
    end else if (ctrlIn.load) begin
      accQ    <= accInVec;
      origQ   <= accInVec;
      opQ     <= mulOpIn;
      maskQ   <= maskIn;
      maskEnQ <= maskEnIn;
      zeroQ   <= zeroModeIn;
    end else if (ctrlIn.stepEn) begin
      accQ <= accNext;
    end
  end

  // R10: captured controls stay fixed across the later steps
  a_r10_capture_held: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlIn.stepEn && ctrlIn.stepIdx != '0) |-> ($stable(maskQ) && $stable(origQ) && $stable(opQ)));
  // R8: the saved original never moves during a step
  a_r8_orig_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlIn.stepEn && !ctrlIn.load) |=> $stable(origQ));
endmodule

// File: rtl/quad_step_dotacc.sv
module quad_step_dotacc
  import qdot_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [IDXW-1:0]  srcIdxIn,
  input  logic [OPW-1:0]   mulOpIn,
  input  logic [VEC-1:0]   accInVec,
  input  logic [LANES-1:0] maskIn,
  input  logic             maskEnIn,
  input  logic             zeroModeIn,
  output logic [IDXW-1:0]  rfIdxOut,
  input  logic [VEC-1:0]   rfDataIn,
  output logic             fetchNeededOut,
  output logic             busyOut,
  output logic             doneOut,
  output logic [VEC-1:0]   resultOut
);
  ctrl_t ctrlBus;

  assign fetchNeededOut = !maskEnIn || (|maskIn);

  qdot_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .srcIdxIn(srcIdxIn),
    .busyOut(busyOut), .doneOut(doneOut), .rfIdxOut(rfIdxOut), .ctrlOut(ctrlBus)
  );

  qdot_lanes uLanes (
    .clk(clk), .rstN(rstN), .ctrlIn(ctrlBus), .mulOpIn(mulOpIn),
    .accInVec(accInVec), .maskIn(maskIn), .maskEnIn(maskEnIn),
    .zeroModeIn(zeroModeIn), .rfDataIn(rfDataIn), .resultOut(resultOut)
  );

  // R2: busy always ends in a done pulse
  a_r2_busy_ends_done: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busyOut)) |-> doneOut);
endmodule

// File: tb/sim_quad_step_dotacc.sv
`timescale 1ns/1ps
module sim_quad_step_dotacc;
  logic clk = 1'b0, rstN = 1'b0, startIn = 1'b0;
  logic [4:0] srcIdxIn = '0, rfIdxOut;
  logic [127:0] mulOpIn = '0;
  logic [511:0] accInVec = '0, rfDataIn, resultOut;
  logic [15:0] maskIn = '0;
  logic maskEnIn = 1'b0, zeroModeIn = 1'b0;
  logic fetchNeededOut, busyOut, doneOut;
  logic [511:0] rfMem [32];
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  assign rfDataIn = rfMem[rfIdxOut];

  quad_step_dotacc u0 (.*);

  task automatic check(bit ok, string req, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] model(logic [4:0] idx, logic [127:0] op, logic [511:0] acc,
                                          logic [15:0] m, bit en, bit zr);
    logic [511:0] r;
    for (int i = 0; i < 16; i++) begin
      int s = acc[32*i +: 32];
      for (int k = 0; k < 4; k++) begin
        logic [511:0] v = rfMem[(idx & 5'b11100) + 5'(k)];
        logic [31:0] t = op[32*k +: 32];
        s += int'($signed(v[32*i +: 16])) * int'($signed(t[15:0]))
           + int'($signed(v[32*i+16 +: 16])) * int'($signed(t[31:16]));
      end
      if (!en || m[i]) r[32*i +: 32] = s;
      else r[32*i +: 32] = zr ? 32'd0 : acc[32*i +: 32];
    end
    return r;
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  task automatic runOp(logic [4:0] idx, logic [127:0] op, logic [511:0] acc, logic [15:0] m,
                       bit en, bit zr, bit disturb, string tag);
    logic [511:0] exp = model(idx, op, acc, m, en, zr);
    logic [4:0] base = idx & 5'b11100;
    @(negedge clk);
    srcIdxIn = idx; mulOpIn = op; accInVec = acc; maskIn = m; maskEnIn = en; zeroModeIn = zr;
    startIn = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k == 0) begin
        startIn = disturb;
        if (disturb) begin
          srcIdxIn = 5'($urandom); mulOpIn = {$urandom, $urandom, $urandom, $urandom};
          accInVec = rnd512(); maskIn = ~m; maskEnIn = !en; zeroModeIn = !zr;
        end
      end
      if (k == 3) startIn = 1'b0;
      check(busyOut && !doneOut, "R2 busy window", {511'd0, busyOut}, 512'd1);
      check(rfIdxOut == base + 5'(k), "R3 read index", 512'(rfIdxOut), 512'(base + 5'(k)));
    end
    @(negedge clk);
    check(doneOut && !busyOut, "R2 done pulse", {510'd0, busyOut, doneOut}, 512'd1);
    check(resultOut == exp, tag, resultOut, exp);
    @(negedge clk);
    check(!doneOut, "R2 done single", {511'd0, doneOut}, 512'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int r = 0; r < 32; r++) rfMem[r] = rnd512();
    repeat (3) @(negedge clk);
    check(!busyOut && !doneOut, "R1 reset state", {510'd0, busyOut, doneOut}, 512'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busyOut && !doneOut, "R1 idle after reset", {510'd0, busyOut, doneOut}, 512'd0);

    // R9 fetch flag
    maskEnIn = 1'b1; maskIn = 16'h0000; #1;
    check(fetchNeededOut == 1'b0, "R9 suppressed", 512'(fetchNeededOut), 512'd0);
    maskIn = 16'h8000; #1;
    check(fetchNeededOut == 1'b1, "R9 one bit set", 512'(fetchNeededOut), 512'd1);
    maskEnIn = 1'b0; maskIn = 16'h0000; #1;
    check(fetchNeededOut == 1'b1, "R9 mask off", 512'(fetchNeededOut), 512'd1);

    // R4 R6 most negative words squared, unmasked
    for (int r = 4; r < 8; r++) rfMem[r] = {32{16'h8000}};
    runOp(5'd6, {8{16'h8000}}, '0, 16'h0000, 1'b0, 1'b0, 1'b0, "R4 R6 min word products");
    // R5 wrap near the top of the range
    for (int r = 8; r < 12; r++) rfMem[r] = {32{16'h7FFF}};
    runOp(5'd11, {8{16'h7FFF}}, {16{32'h7FFF_FFFF}}, 16'hFFFF, 1'b1, 1'b0, 1'b0, "R5 wrap");
    // R7 zeroing and R8 merge with mixed masks
    for (int r = 0; r < 32; r++) rfMem[r] = rnd512();
    runOp(5'd17, {$urandom, $urandom, $urandom, $urandom}, rnd512(), 16'hA5C3, 1'b1, 1'b1, 1'b0, "R7 zeroing");
    runOp(5'd2, {$urandom, $urandom, $urandom, $urandom}, rnd512(), 16'h3C5A, 1'b1, 1'b0, 1'b0, "R8 merge");
    runOp(5'd30, {$urandom, $urandom, $urandom, $urandom}, rnd512(), 16'h0000, 1'b1, 1'b0, 1'b0, "R8 all merged");
    // R10 disturbed inputs and start held while busy
    runOp(5'd13, {$urandom, $urandom, $urandom, $urandom}, rnd512(), 16'h0F0F, 1'b1, 1'b1, 1'b1, "R10 capture");
    // random mix
    for (int n = 0; n < 40; n++) begin
      for (int r = 0; r < 32; r++) rfMem[r] = rnd512();
      runOp(5'($urandom), {$urandom, $urandom, $urandom, $urandom}, rnd512(), 16'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), "R4 R6 random");
    end
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule